// File: doc/BRIEF.md
# Sound Coprocessor Interrupt and Ownership Flag Block

This block sits on the I/O port space of a small sound processor. It collects two interrupt sources into one level-sensitive interrupt request for that processor. The first source is the interrupt level coming from the sound synthesis chip. The second is a request pulse from the host processor. The block also keeps two ownership flags that the two processors use to arbitrate a shared memory: one flag belongs to the host side and one to the sound side.

The sound processor controls the block through I/O writes and reads. Only the low eight bits of the port address are decoded. A write to certain ports acknowledges an interrupt source or changes the sound-side flag, and the data on the bus is ignored. Two ports can be read. The first gives the host-side flag together with the host-interrupt pending bit. The second passes two active-high coin inputs straight through.

A rising edge of the synthesis-chip level sets two pending bits. One of them follows the level and drops when the level falls. The other stays set until the sound processor acknowledges it. This means a short pulse from the chip is never lost. The host side drives the host-side flag with separate take and give strobes, and it reads the sound-side flag back on a status output.

Top module: `sndirq_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, all three pending bits and both flags are zero, `cpu_irq` is low, `host_flags` reads 0 and port 0x20 reads 0.
- R2: A rising edge of `chip_irq_lvl` sets pending bit 0 (level copy) and pending bit 2 (sticky copy) together; `cpu_irq` is high one clock after the edge is sampled.
- R3: A falling edge of `chip_irq_lvl` clears pending bit 0 only; bit 2 keeps `cpu_irq` high until it is acknowledged.
- R4: An I/O write to port 0x12 clears pending bit 2 and leaves bits 0 and 1 unchanged.
- R5: A `host_irq_req` pulse sets pending bit 1; an I/O write to port 0x13 clears it.
- R6: `cpu_irq` is high whenever any of the three pending bits is set and low only when all three are zero.
- R7: An I/O write to port 0x10 sets the sound-side flag and a write to port 0x11 clears it, whatever the write data; the flag is visible in bit 0 of `host_flags`.
- R8: `host_sem_take` sets the host-side flag and `host_sem_give` clears it.
- R9: A read of port 0x30 returns `coin_in[0]` in bit 0 and `coin_in[1]` in bit 1.
- R10: Port decoding uses only `io_addr[7:0]`; the upper address bits have no effect on any read or write.
- R11: When a set and a clear of the same pending bit or flag arrive in one cycle, the bit ends up set.
- R12: A read of port 0x20 returns the host-side flag in bit 0 and pending bit 1 in bit 1. Every other bit of every read, every unmapped port, and `io_rdata` while `io_rd` is low all read zero. Writes to unmapped ports change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_irq_lvl | input | 1 | Interrupt level from the sound synthesis chip |
| host_irq_req | input | 1 | Interrupt request pulse from the host |
| host_sem_take | input | 1 | Host strobe that sets the host-side flag |
| host_sem_give | input | 1 | Host strobe that clears the host-side flag |
| io_wr | input | 1 | I/O write strobe from the sound processor |
| io_rd | input | 1 | I/O read strobe from the sound processor |
| io_addr | input | ADDR_W | I/O port address; only the low 8 bits are decoded |
| io_wdata | input | DATA_W | I/O write data (ignored by every port) |
| coin_in | input | COIN_W | Active-high coin inputs |
| cpu_irq | output | 1 | Level interrupt request to the sound processor |
| io_rdata | output | DATA_W | I/O read data, combinational while io_rd is high |
| host_flags | output | DATA_W | Host read path: sound-side flag in bit 0 |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume the interrupt level is sampled only at rising edges, so that a rise or fall is seen as a change between two sampled values. The host strobes and the I/O strobes are treated as one request per sampled cycle. The bench changes every input only at the falling clock edge and holds it for a full period. It reads the combinational read bus a short time after that edge, so no check depends on how the tool orders events at the rising edge. Sweeps cover all 256 low port addresses, for reads and for writes, with random upper address bits. They run across each combination of host-side flag, host pending bit and coin value.

// File: rtl/sndirq_pkg.sv
package sndirq_pkg;

    localparam int DATA_W = 8;
    localparam int DEC_W  = 8;
    localparam int COIN_W = 2;
    localparam int PEND_W = 3;

    // pending bit positions
    localparam int PB_CHIP_LVL    = 0;
    localparam int PB_HOST        = 1;
    localparam int PB_CHIP_STICKY = 2;

    // decoded port numbers (low address byte)
    localparam logic [DEC_W-1:0] PORT_LSEM_SET = 8'h10;
    localparam logic [DEC_W-1:0] PORT_LSEM_CLR = 8'h11;
    localparam logic [DEC_W-1:0] PORT_ACK_CHIP = 8'h12;
    localparam logic [DEC_W-1:0] PORT_ACK_HOST = 8'h13;
    localparam logic [DEC_W-1:0] PORT_STATUS   = 8'h20;
    localparam logic [DEC_W-1:0] PORT_COIN     = 8'h30;

    typedef struct packed {
        logic lsem_set;
        logic lsem_clr;
        logic ack_chip;
        logic ack_host;
    } wr_stb_t;

    typedef enum logic [1:0] {
        RSEL_NONE   = 2'd0,
        RSEL_STATUS = 2'd1,
        RSEL_COIN   = 2'd2
    } rsel_e;

    // set wins over clear
    function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/sndirq_decode.sv
module sndirq_decode
    import sndirq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output wr_stb_t           wstb,
    output rsel_e             rsel
);
    localparam int HI_W = ADDR_W - DEC_W;

    logic [DEC_W-1:0] lo;
    logic             unused_bits;

    assign lo          = io_addr[DEC_W-1:0];
    assign unused_bits = ^{io_addr[ADDR_W-1:ADDR_W-HI_W], io_wdata};

    always_comb begin
        wstb.lsem_set = io_wr && (lo == PORT_LSEM_SET);
        wstb.lsem_clr = io_wr && (lo == PORT_LSEM_CLR);
        wstb.ack_chip = io_wr && (lo == PORT_ACK_CHIP);
        wstb.ack_host = io_wr && (lo == PORT_ACK_HOST);
    end

    always_comb begin
        rsel = RSEL_NONE;
        if (io_rd) begin
            case (lo)
                PORT_STATUS: rsel = RSEL_STATUS;
                PORT_COIN:   rsel = RSEL_COIN;
                default:     rsel = RSEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sndirq_pending.sv
module sndirq_pending
    import sndirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_lvl,
    input  logic              host_req,
    input  logic              ack_chip,
    input  logic              ack_host,
    output logic [PEND_W-1:0] pend
);
    logic              lvl_q;
    logic              chip_rise;
    logic              chip_fall;
    logic [PEND_W-1:0] set_v;
    logic [PEND_W-1:0] clr_v;

    assign chip_rise = chip_lvl & ~lvl_q;
    assign chip_fall = ~chip_lvl & lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= chip_lvl;
    end

    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[PB_CHIP_LVL]    = chip_rise;
        clr_v[PB_CHIP_LVL]    = chip_fall;
        set_v[PB_HOST]        = host_req;
        clr_v[PB_HOST]        = ack_host;
        set_v[PB_CHIP_STICKY] = chip_rise;
        clr_v[PB_CHIP_STICKY] = ack_chip;
    end

    for (genvar g = 0; g < PEND_W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) pend[g] <= 1'b0;
            else     pend[g] <= sticky_next(pend[g], set_v[g], clr_v[g]);
        end
    end

    // R2: sampled rise of the chip level sets both chip bits
    p_rise_sets_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(chip_lvl) |=> (pend[PB_CHIP_LVL] && pend[PB_CHIP_STICKY]));

    // R3: a fall clears the level copy
    p_fall_clears_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(chip_lvl) |=> !pend[PB_CHIP_LVL]);

    // R4: acknowledge without a new rise clears the sticky copy, leaves host bit
    p_ack_chip_r4: assert property (@(posedge clk) disable iff (rst)
        (ack_chip && !$rose(chip_lvl) && !host_req && !ack_host)
        |=> (!pend[PB_CHIP_STICKY] && pend[PB_HOST] == $past(pend[PB_HOST])));

    // R5 / R11: host request sets bit 1 even with a simultaneous acknowledge
    p_host_set_r5: assert property (@(posedge clk) disable iff (rst)
        host_req |=> pend[PB_HOST]);

    p_host_clr_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_host && !host_req) |=> !pend[PB_HOST]);

endmodule

// File: rtl/sndirq_sems.sv
module sndirq_sems (
    input  logic clk,
    input  logic rst,
    input  logic host_take,
    input  logic host_give,
    input  logic lsem_set,
    input  logic lsem_clr,
    output logic main_sem,
    output logic local_sem
);
    import sndirq_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            main_sem  <= 1'b0;
            local_sem <= 1'b0;
        end else begin
            main_sem  <= sticky_next(main_sem,  host_take, host_give);
            local_sem <= sticky_next(local_sem, lsem_set,  lsem_clr);
        end
    end

    // R8 / R11: take wins over give
    p_take_r8: assert property (@(posedge clk) disable iff (rst)
        host_take |=> main_sem);

    p_give_r8: assert property (@(posedge clk) disable iff (rst)
        (host_give && !host_take) |=> !main_sem);

    // R7
    p_lsem_set_r7: assert property (@(posedge clk) disable iff (rst)
        lsem_set |=> local_sem);

    p_lsem_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (lsem_clr && !lsem_set) |=> !local_sem);

    p_lsem_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!lsem_set && !lsem_clr) |=> $stable(local_sem));

endmodule

// File: rtl/sndirq_rdmux.sv
module sndirq_rdmux
    import sndirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rsel_e             rsel,
    input  logic              main_sem,
    input  logic              host_pend,
    input  logic [COIN_W-1:0] coin,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (rsel)
            RSEL_STATUS: begin
                rdata[0] = main_sem;
                rdata[1] = host_pend;
            end
            RSEL_COIN:   rdata[COIN_W-1:0] = coin;
            default:     rdata = '0;
        endcase
    end

    // R12: nothing is driven when no mapped port is read
    p_idle_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (rsel == RSEL_NONE) |-> (rdata == '0));

    // R12: status bit 1 tracks the host pending bit
    p_status_host_r12: assert property (@(posedge clk) disable iff (rst)
        (rsel == RSEL_STATUS) |-> (rdata[1] == host_pend && rdata[DATA_W-1:2] == '0));

endmodule

// File: rtl/sndirq_ctrl.sv
module sndirq_ctrl
    import sndirq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_irq_lvl,
    input  logic              host_irq_req,
    input  logic              host_sem_take,
    input  logic              host_sem_give,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic [COIN_W-1:0] coin_in,
    output logic              cpu_irq,
    output logic [DATA_W-1:0] io_rdata,
    output logic [DATA_W-1:0] host_flags
);
    wr_stb_t           wstb;
    rsel_e             rsel;
    logic [PEND_W-1:0] pend;
    logic              main_sem;
    logic              local_sem;

    sndirq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .wstb     (wstb),
        .rsel     (rsel)
    );

    sndirq_pending u_pending (
        .clk      (clk),
        .rst      (rst),
        .chip_lvl (chip_irq_lvl),
        .host_req (host_irq_req),
        .ack_chip (wstb.ack_chip),
        .ack_host (wstb.ack_host),
        .pend     (pend)
    );

    sndirq_sems u_sems (
        .clk       (clk),
        .rst       (rst),
        .host_take (host_sem_take),
        .host_give (host_sem_give),
        .lsem_set  (wstb.lsem_set),
        .lsem_clr  (wstb.lsem_clr),
        .main_sem  (main_sem),
        .local_sem (local_sem)
    );

    sndirq_rdmux u_rdmux (
        .clk       (clk),
        .rst       (rst),
        .rsel      (rsel),
        .main_sem  (main_sem),
        .host_pend (pend[PB_HOST]),
        .coin      (coin_in),
        .rdata     (io_rdata)
    );

    assign cpu_irq = |pend;

    always_comb begin
        host_flags    = '0;
        host_flags[0] = local_sem;
    end

    // R1: interrupt is low in the cycle that follows a reset cycle
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!cpu_irq && host_flags == '0));

    // R6: a host request always raises the interrupt on the next cycle
    p_host_irq_r6: assert property (@(posedge clk) disable iff (rst)
        host_irq_req |=> cpu_irq);

endmodule

// File: tb/sndirq_ctrl_tb.sv
`timescale 1ns/1ps
module sndirq_ctrl_tb;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              chip_irq_lvl = 1'b0;
    logic              host_irq_req = 1'b0;
    logic              host_sem_take = 1'b0;
    logic              host_sem_give = 1'b0;
    logic              io_wr = 1'b0;
    logic              io_rd = 1'b0;
    logic [ADDR_W-1:0] io_addr = '0;
    logic [7:0]        io_wdata = '0;
    logic [1:0]        coin_in = '0;
    logic              cpu_irq;
    logic [7:0]        io_rdata;
    logic [7:0]        host_flags;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [2:0] m_pend  = '0;
    logic       m_main  = 1'b0;
    logic       m_local = 1'b0;
    logic       m_prev  = 1'b0;

    always #2.5 clk = ~clk;

    sndirq_ctrl #(.ADDR_W(ADDR_W)) u_dut (
        .clk, .rst, .chip_irq_lvl, .host_irq_req, .host_sem_take, .host_sem_give,
        .io_wr, .io_rd, .io_addr, .io_wdata, .coin_in,
        .cpu_irq, .io_rdata, .host_flags
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        chk({7'b0, cpu_irq}, {7'b0, |m_pend}, tag);
        chk(host_flags, {7'b0, m_local}, tag);
    endtask

    // one clock with the given stimulus, then model update and output check
    task automatic tick(input logic lvl, input logic hreq, input logic take, input logic give,
                        input logic wr, input logic [7:0] lo, input string tag);
        logic [7:0] a;
        logic rise, fall;
        chip_irq_lvl  = lvl;
        host_irq_req  = hreq;
        host_sem_take = take;
        host_sem_give = give;
        io_wr         = wr;
        io_addr       = {8'($urandom), lo};
        io_wdata      = 8'($urandom);
        @(negedge clk);
        a    = lo;
        rise = lvl & ~m_prev;
        fall = ~lvl & m_prev;
        m_pend[0] = rise | (m_pend[0] & ~fall);
        m_pend[1] = hreq | (m_pend[1] & ~(wr && a == 8'h13));
        m_pend[2] = rise | (m_pend[2] & ~(wr && a == 8'h12));
        m_main    = take | (m_main & ~give);
        m_local   = (wr && a == 8'h10) | (m_local & ~(wr && a == 8'h11));
        m_prev    = lvl;
        host_irq_req = 1'b0; host_sem_take = 1'b0; host_sem_give = 1'b0; io_wr = 1'b0;
        check_outs(tag);
    endtask

    task automatic rd_check(input logic [7:0] lo, input logic [7:0] hi, input string tag);
        logic [7:0] exp;
        io_rd   = 1'b1;
        io_addr = {hi, lo};
        #1;
        if (lo == 8'h20)      exp = {6'b0, m_pend[1], m_main};
        else if (lo == 8'h30) exp = {6'b0, coin_in};
        else                  exp = 8'h00;
        chk(io_rdata, exp, tag);
        io_rd = 1'b0;
        #0.5;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({7'b0, cpu_irq}, 8'h00, "R1 irq in reset");
        rd_check(8'h20, 8'h00, "R1 status in reset");
        rst = 1'b0;
        @(negedge clk);
        check_outs("R1 after reset");
        rd_check(8'h20, 8'h00, "R1 status after reset");

        // R2 / R4 / R3: rise, ack while level high, then fall
        tick(1, 0, 0, 0, 0, 8'h00, "R2 rise raises irq");
        tick(1, 0, 0, 0, 1, 8'h12, "R4 ack keeps level bit");
        tick(0, 0, 0, 0, 0, 8'h00, "R3 fall after ack drops irq");
        // R3: short pulse leaves sticky bit
        tick(1, 0, 0, 0, 0, 8'h00, "R2 second rise");
        tick(0, 0, 0, 0, 0, 8'h00, "R3 sticky holds irq");
        tick(0, 0, 0, 0, 1, 8'h12, "R4 ack clears sticky");

        // R5 / R6
        tick(0, 1, 0, 0, 0, 8'h00, "R5 host request R6 irq");
        rd_check(8'h20, 8'h5a, "R5 status bit1 set");
        tick(0, 0, 0, 0, 1, 8'h13, "R5 host ack");
        rd_check(8'h20, 8'h00, "R5 status bit1 cleared");

        // R4: chip ack leaves host bit
        tick(0, 1, 0, 0, 0, 8'h00, "R4 setup host");
        tick(1, 0, 0, 0, 0, 8'h00, "R4 setup rise");
        tick(0, 0, 0, 0, 0, 8'h00, "R4 setup fall");
        tick(0, 0, 0, 0, 1, 8'h12, "R4 ack keeps host bit");
        rd_check(8'h20, 8'h00, "R4 host bit intact");
        tick(0, 0, 0, 0, 1, 8'h13, "R6 all clear drops irq");

        // R8 / R7
        tick(0, 0, 1, 0, 0, 8'h00, "R8 take");
        rd_check(8'h20, 8'hc3, "R8 flag visible");
        tick(0, 0, 0, 1, 0, 8'h00, "R8 give");
        rd_check(8'h20, 8'h00, "R8 flag cleared");
        tick(0, 0, 0, 0, 1, 8'h10, "R7 local set");
        tick(0, 0, 0, 0, 1, 8'h11, "R7 local clear");

        // R11: same-cycle set and clear
        tick(0, 1, 0, 0, 1, 8'h13, "R11 host set beats ack");
        rd_check(8'h20, 8'h00, "R11 host bit kept");
        tick(0, 0, 1, 1, 0, 8'h00, "R11 take beats give");
        rd_check(8'h20, 8'h00, "R11 flag kept");
        tick(1, 0, 0, 0, 1, 8'h12, "R11 rise beats ack");
        tick(0, 0, 0, 0, 0, 8'h00, "R11 sticky survived");
        tick(0, 0, 0, 1, 1, 8'h12, "R11 cleanup");
        tick(0, 0, 0, 0, 1, 8'h13, "R11 cleanup host");

        // R12: idle read bus
        io_addr = 16'h0030; coin_in = 2'b11; #1;
        chk(io_rdata, 8'h00, "R12 no read strobe");
        #0.5;

        // R9 / R10 / R12: read sweep over state, coin and all low addresses
        for (int s = 0; s < 4; s++) begin
            if (s[0] != m_main) tick(0, 0, s[0], ~s[0], 0, 8'h00, "R8 sweep setup");
            if (s[1] && !m_pend[1]) tick(0, 1, 0, 0, 0, 8'h00, "R5 sweep setup");
            if (!s[1] && m_pend[1]) tick(0, 0, 0, 0, 1, 8'h13, "R5 sweep setup");
            for (int c = 0; c < 4; c++) begin
                coin_in = 2'(c);
                for (int a = 0; a < 256; a++) begin
                    rd_check(8'(a), 8'($urandom), "R9 R10 R12 read sweep");
                    @(negedge clk);
                end
            end
        end

        // R10 / R12: write sweep over all low addresses with random upper bits
        for (int a = 0; a < 256; a++) begin
            if (!m_pend[1]) tick(0, 1, 0, 0, 0, 8'h00, "R5 write sweep setup");
            if (!m_pend[2]) begin
                tick(1, 0, 0, 0, 0, 8'h00, "R2 write sweep setup");
                tick(0, 0, 0, 0, 0, 8'h00, "R3 write sweep setup");
            end
            tick(0, 0, 0, 0, 1, 8'(a), "R10 R12 write sweep");
            rd_check(8'h20, 8'($urandom), "R10 R12 status after write");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule